// File: doc/BRIEF.md
# Truncated Partial-Product Multiplier

This block multiplies two unsigned operands by summing explicit partial-product bits instead of using a hard multiplier. Any bit pair whose combined weight is below a cut-off `K` is left out of the sum. This trades product precision for adder logic. Its intended use is to study how approximate products affect an iterative reciprocal or divider loop.

After the kept terms are summed, a half-LSB bias of `2^(K-1)` is added. The low `K` bits are then forced to zero. With `K = 0` the block gives the exact product.

An optional output register adds one cycle of latency and a valid strobe. The register loads only on a valid input and otherwise holds its last product.

Top module: `mtr_mul`

## Requirements
- R1: With the output register enabled, `out_valid` reads 0 in the first cycle after a cycle with `rst` high.
- R2: For every pair (i, j) where bit i of `op_a` and bit j of `op_b` are both 1 and i+j >= K, the value 2^(i+j) is part of the accumulated sum. For example, with K=8, `op_a`=0x100 and `op_b`=1 give 0x100.
- R3: A pair with i+j < K adds nothing. For example, with K=8, `op_a`=0x80 and `op_b`=1 give 0, and `op_a`=`op_b`=1 give 0.
- R4: When K > 0, the bias 2^(K-1) is added to the accumulated sum (modulo 2^(2·OP_W)), and bits K-1..0 of the result are then cleared. A valid product therefore always has its low K bits at zero.
- R5: With K=0, no bias is added and the product equals the exact unsigned product `op_a`×`op_b`.
- R6: With the output register enabled, `out_valid` in a cycle equals `in_valid` of the previous cycle. The product sampled with a valid input appears on `product` one cycle later.
- R7: With the output register disabled, `out_valid` equals `in_valid` in the same cycle, and `product` is the combinational result of the current operands.
- R8: With the output register enabled, a cycle with `in_valid` low leaves `product` unchanged, whatever the operands do.
- R9: With the output register enabled, `product` reads 0 in the cycle after `rst` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on `op_a`/`op_b` are valid |
| op_a | input | OP_W | Unsigned multiplicand |
| op_b | input | OP_W | Unsigned multiplier |
| out_valid | output | 1 | `product` carries a result |
| product | output | 2·OP_W | Truncated, rounded product |

## Verification
The bound checker watches several properties on every clock:
- the one-cycle valid delay and the reset values of the register;
- that the product holds while no valid input arrives;
- that a zero operand yields a zero product;
- that the cleared low bits stay zero;
- in the combinational variant, that the valid passes straight through.

Whether each kept or dropped bit pair is weighted correctly can only be shown by the bench. Its behavioural model sums bit pairs one at a time and is compared every cycle. The bench drives it with weight-boundary operands, all-ones, zero and a long pseudo-random stream. It also runs a second instance with K=0 against the exact product.

// File: rtl/mtr_pkg.sv
package mtr_pkg;

    localparam int DEF_OP_W = 32;
    localparam int DEF_K    = 8;

    // number of nodes on level lvl of a pairwise reduction of n leaves
    function automatic int nodes_at(input int n, input int lvl);
        int c;
        c = n;
        for (int s = 0; s < lvl; s++) begin
            c = (c + 1) / 2;
        end
        return c;
    endfunction

    // number of pairwise levels needed to reduce n leaves to one
    function automatic int depth_of(input int n);
        int c;
        int d;
        c = n;
        d = 0;
        while (c > 1) begin
            c = (c + 1) / 2;
            d++;
        end
        return d;
    endfunction

endpackage

// File: rtl/mtr_pp_gen.sv
module mtr_pp_gen #(
    parameter int OP_W = 32,
    parameter int K    = 8
) (
    input  logic [OP_W-1:0]                 a,
    input  logic [OP_W-1:0]                 b,
    output logic [OP_W-1:0][2*OP_W-1:0]     rows
);
    localparam int PROD_W = 2 * OP_W;

    // one row per multiplicand bit; bits below weight K are never formed
    always_comb begin
        rows = '0;
        for (int r = 0; r < OP_W; r++) begin
            for (int c = 0; c < OP_W; c++) begin
                if (r + c >= K) begin
                    rows[r][r+c] = a[r] & b[c];
                end
            end
        end
    end

    logic unused_w;
    assign unused_w = (PROD_W == 0);

endmodule

// File: rtl/mtr_sum_tree.sv
module mtr_sum_tree
    import mtr_pkg::*;
#(
    parameter int N = 32,
    parameter int W = 64
) (
    input  logic [N-1:0][W-1:0] leaves,
    output logic [W-1:0]        sum
);
    localparam int LEVELS = depth_of(N);

    for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
        localparam int CNT = nodes_at(N, l);
        logic [W-1:0] v [CNT];
        if (l == 0) begin : g_leaf
            for (genvar k = 0; k < CNT; k++) begin : g_k
                assign v[k] = leaves[k];
            end
        end else begin : g_add
            localparam int PREV = nodes_at(N, l - 1);
            for (genvar k = 0; k < CNT; k++) begin : g_k
                if (2 * k + 1 < PREV) begin : g_pair
                    assign v[k] = g_lvl[l-1].v[2*k] + g_lvl[l-1].v[2*k+1];
                end else begin : g_pass
                    assign v[k] = g_lvl[l-1].v[2*k];
                end
            end
        end
    end

    assign sum = g_lvl[LEVELS].v[0];

endmodule

// File: rtl/mtr_round.sv
module mtr_round #(
    parameter int W = 64,
    parameter int K = 8
) (
    input  logic [W-1:0] sum_in,
    output logic [W-1:0] res
);
    if (K == 0) begin : g_exact
        assign res = sum_in;
    end else begin : g_round
        localparam logic [W-1:0] ONE  = W'(1);
        localparam logic [W-1:0] BIAS = ONE << (K - 1);
        localparam logic [W-1:0] KEEP = ~((ONE << K) - ONE);
        logic [W-1:0] biased;
        assign biased = sum_in + BIAS;   // carry out of the top bit is dropped
        assign res    = biased & KEEP;
    end

endmodule

// File: rtl/mtr_mul.sv
module mtr_mul
    import mtr_pkg::*;
#(
    parameter int OP_W    = DEF_OP_W,
    parameter int K       = DEF_K,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [OP_W-1:0]     op_a,
    input  logic [OP_W-1:0]     op_b,
    output logic                out_valid,
    output logic [2*OP_W-1:0]   product
);
    localparam int PROD_W = 2 * OP_W;

    logic [OP_W-1:0][PROD_W-1:0] pp_rows;
    logic [PROD_W-1:0]           pp_sum;
    logic [PROD_W-1:0]           rounded;

    mtr_pp_gen #(.OP_W(OP_W), .K(K)) u_pp (
        .a    (op_a),
        .b    (op_b),
        .rows (pp_rows)
    );

    mtr_sum_tree #(.N(OP_W), .W(PROD_W)) u_tree (
        .leaves (pp_rows),
        .sum    (pp_sum)
    );

    mtr_round #(.W(PROD_W), .K(K)) u_rnd (
        .sum_in (pp_sum),
        .res    (rounded)
    );

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                out_valid <= 1'b0;
                product   <= '0;
            end else begin
                out_valid <= in_valid;
                if (in_valid) begin
                    product <= rounded;
                end
            end
        end
    end else begin : g_comb
        assign out_valid = in_valid;
        assign product   = rounded;
    end

endmodule

// File: rtl/mtr_mul_chk.sv
module mtr_mul_chk #(
    parameter int OP_W    = 32,
    parameter int K       = 8,
    parameter bit OUT_REG = 1'b1
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [OP_W-1:0]     op_a,
    input logic [OP_W-1:0]     op_b,
    input logic                out_valid,
    input logic [2*OP_W-1:0]   product
);
    localparam int PROD_W = 2 * OP_W;
    localparam logic [PROD_W-1:0] ONE  = PROD_W'(1);
    localparam logic [PROD_W-1:0] LOWM = (ONE << K) - ONE;

    if (OUT_REG) begin : g_reg
        AST_RESET_VALID: assert property (@(posedge clk) rst |=> !out_valid);                                   // R1
        AST_RESET_PROD:  assert property (@(posedge clk) rst |=> (product == '0));                              // R9
        AST_VALID_RISE:  assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);             // R6
        AST_VALID_DROP:  assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid);           // R6
        AST_HOLD_PROD:   assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(product));     // R8
        AST_ZERO_OPND:   assert property (@(posedge clk) disable iff (rst)
                             (in_valid && (op_a == '0 || op_b == '0)) |=> (product == '0));                    // R3
        if (K > 0) begin : g_low
            AST_LOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
                               out_valid |-> ((product & LOWM) == '0));                                          // R4
        end
    end else begin : g_comb
        AST_VALID_PASS: assert property (@(posedge clk) disable iff (rst) out_valid == in_valid);               // R7
        if (K > 0) begin : g_low
            AST_LOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
                               out_valid |-> ((product & LOWM) == '0));                                          // R4
        end else begin : g_exact
            AST_EXACT: assert property (@(posedge clk) disable iff (rst)
                           in_valid |-> (product == {{OP_W{1'b0}}, op_a} * {{OP_W{1'b0}}, op_b}));               // R5
        end
    end

endmodule

bind mtr_mul mtr_mul_chk #(.OP_W(OP_W), .K(K), .OUT_REG(OUT_REG)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .product   (product)
);

// File: tb/mtr_mul_tb.sv
module mtr_mul_tb_top;

    localparam int OP_W = 32;
    localparam int KV   = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [31:0]     op_a = '0;
    logic [31:0]     op_b = '0;
    logic            ov_r;
    logic [63:0]     pr_r;
    logic            ov_c;
    logic [63:0]     pr_c;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    run_chk  = 1'b0;
    bit    done     = 1'b0;
    string tag      = "R2";

    always #10 clk = ~clk;   // 50 MHz

    mtr_mul #(.OP_W(OP_W), .K(KV), .OUT_REG(1'b1)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .out_valid(ov_r), .product(pr_r)
    );

    mtr_mul #(.OP_W(OP_W), .K(0), .OUT_REG(1'b0)) dut_k0_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .out_valid(ov_c), .product(pr_c)
    );

    // behavioural reference: add kept bit pairs one by one, bias, clear
    function automatic logic [63:0] ref_mul(input logic [31:0] a, input logic [31:0] b, input int k);
        logic [63:0] acc;
        acc = '0;
        for (int i = 0; i < 32; i++) begin
            for (int j = 0; j < 32; j++) begin
                if (a[i] && b[j] && (i + j >= k)) acc = acc + (64'd1 << (i + j));
            end
        end
        if (k > 0) begin
            acc = acc + (64'd1 << (k - 1));
            acc = acc & ~((64'd1 << k) - 64'd1);
        end
        return acc;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // cycle model of the registered instance
    logic        m_vld = 1'b0;
    logic [63:0] m_prod = '0;
    always @(posedge clk) begin
        if (rst) begin
            m_vld  <= 1'b0;
            m_prod <= '0;
        end else begin
            m_vld <= in_valid;
            if (in_valid) m_prod <= ref_mul(op_a, op_b, KV);
        end
    end

    always @(negedge clk) begin
        if (run_chk) begin
            check("R6", {63'd0, ov_r}, {63'd0, m_vld});
            check(tag, pr_r, m_prod);
            check("R7", {63'd0, ov_c}, {63'd0, in_valid});
            if (in_valid) check("R5", pr_c, {32'd0, op_a} * {32'd0, op_b});
        end
    end

    task automatic drive(input logic v, input logic [31:0] a, input logic [31:0] b);
        @(posedge clk);
        #1;
        in_valid = v;
        op_a     = a;
        op_b     = b;
    endtask

    initial begin
        logic [31:0] lfsr;
        logic [63:0] held;
        lfsr = 32'hACE1_2345;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R1", {63'd0, ov_r}, 64'd0);
        check("R9", pr_r, 64'd0);
        run_chk = 1'b1;

        tag = "R3";
        drive(1'b1, 32'h1, 32'h1);
        drive(1'b1, 32'h80, 32'h1);
        drive(1'b1, 32'h0, 32'hFFFF_FFFF);
        drive(1'b0, 32'h0, 32'h0);
        @(negedge clk);
        check("R3", pr_r, 64'd0);

        tag = "R2";
        drive(1'b1, 32'h100, 32'h1);
        drive(1'b0, 32'h0, 32'h0);
        @(negedge clk);
        check("R2", pr_r, 64'h100);
        drive(1'b1, 32'hFF, 32'hFF);
        drive(1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        drive(1'b1, 32'h8000_0000, 32'h8000_0000);
        drive(1'b0, 32'h0, 32'h0);
        @(negedge clk);
        check("R2", pr_r, 64'h4000_0000_0000_0000);

        tag = "R4";
        drive(1'b1, 32'h0000_01FF, 32'h0000_00F3);
        drive(1'b0, 32'h0, 32'h0);
        @(negedge clk);
        check("R4", pr_r & 64'hFF, 64'd0);

        // hold: operands change with no valid
        tag = "R8";
        held = pr_r;
        for (int n = 0; n < 6; n++) begin
            drive(1'b0, 32'h1234_0000 + n, 32'hF00F_0000 ^ n);
        end
        @(negedge clk);
        check("R8", pr_r, held);

        // toggling valid, then long pseudo-random stream
        tag = "R6";
        for (int n = 0; n < 300; n++) begin
            logic [31:0] a;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = lfsr;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            if (n >= 20) tag = "R2";
            drive((n % 5) != 3, (n % 7 == 0) ? (a >> (n % 31)) : a, lfsr);
        end

        // reset in mid-stream
        drive(1'b1, 32'hDEAD_BEEF, 32'h1357_9BDF);
        run_chk = 1'b0;
        @(posedge clk);
        #1 rst = 1'b1;
        @(posedge clk);
        #1 rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        check("R1", {63'd0, ov_r}, 64'd0);
        check("R9", pr_r, 64'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule